// File: doc/BRIEF.md
# Conversion Frame Sequencer with Result Hold Register

This block paces one conversion of an 8-bit successive-approximation converter. A small counter repeats a twelve-clock frame. Three positions in that frame are decoded into registered single-clock pulses. The first tells the result register to take the finished code. The second starts a new acquisition in the sample-and-hold stage. The third wraps the counter and tells the approximation logic to begin again on the sample that is now held.

The result register takes the code from the approximation logic only on the load pulse. At all other times it keeps its value on a parallel output, so downstream logic never sees the bits while they are still being shifted. Frame length, the three decode positions, the counter width, the code width and the polarity of the sample/hold control are all parameters, and their consistency is checked at elaboration.

Top module: `conv_frame_seq`

## Requirements
- R1: While reset is high, and on the first clock after it is released, `code_o` is 0x00 and `load_o`, `sh_ctrl_o` and `restart_o` are all low. The internal count is 0.
- R2: After reset is released, the count becomes 1 on the first rising edge and then rises by one per clock up to 12. From 12 it goes back to 1, so every frame after reset lasts exactly 12 clocks.
- R3: `load_o` is high for exactly the one clock that follows the clock in which the count is 10. The first such pulse is seen after the 11th rising edge following reset release.
- R4: `sh_ctrl_o` is high, meaning track, for exactly the one clock that follows the clock in which the count is 11. Its falling edge starts the hold interval in which the conversion runs.
- R5: `restart_o` is high for exactly the one clock that follows the clock in which the count is 12. This is the clock in which the count is back at 1.
- R6: No two of `load_o`, `sh_ctrl_o` and `restart_o` are high in the same clock. Each is high exactly once in every 12 clocks, and they appear in the order load, sample, restart on consecutive clocks.
- R7: On a rising edge at which `load_o` is high, `code_o` takes the value of `code_i`. That value is visible from the following clock.
- R8: On every other rising edge, `code_o` keeps its value whatever `code_i` does.
- R9: A reset asserted in the middle of a frame returns the block to the R1 state. After release, the frame restarts exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| code_i | input | 8 | Code produced by the approximation logic |
| sh_ctrl_o | output | 1 | Sample/hold control, high = track |
| restart_o | output | 1 | One-clock pulse that restarts the approximation |
| load_o | output | 1 | One-clock pulse on which the result register captures |
| code_o | output | 8 | Held conversion result |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a 4-bit counter, a 12-clock frame, and decodes at 10, 11 and 12. With a frame this short, a few hundred clocks pass through every count position more than twenty times. The bench drives a different code on every clock, so any capture off the load pulse changes the output and is caught. A second sweep follows a reset asserted in the middle of a frame and confirms that the phase restarts from the beginning.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   typedef enum int unsigned {
      EV_LOAD   = 0,
      EV_SAMPLE = 1,
      EV_WRAP   = 2
   } seq_event_e;

   localparam int unsigned NUM_EVENTS = 3;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      int unsigned b;
      b = 1;
      while ((1 << b) <= max_val) b++;
      return b;
   endfunction

endpackage

// File: rtl/frame_counter.sv
module frame_counter #(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned LAST    = 12,
   parameter int unsigned FIRST   = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST);
   localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(FIRST);
   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (cnt_q == LAST_V) cnt_d = FIRST_V;
      else                 cnt_d = cnt_q + ONE_V;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/event_pulse.sv
module event_pulse #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned AT    = 10
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             pulse_o
);
   localparam logic [CNT_W-1:0] AT_V = CNT_W'(AT);

   logic hit;
   logic pulse_q;

   assign hit = (cnt_i == AT_V);

   always_ff @(posedge clk_i) begin
      if (rst_i) pulse_q <= 1'b0;
      else       pulse_q <= hit;
   end

   assign pulse_o = pulse_q;
endmodule

// File: rtl/result_hold.sv
module result_hold #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              take_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       code_q <= '0;
      else if (take_i) code_q <= code_i;
   end

   assign code_o = code_q;
endmodule

// File: rtl/conv_frame_seq.sv
module conv_frame_seq
   import conv_seq_pkg::*;
#(
   parameter int unsigned CODE_W        = 8,
   parameter int unsigned FRAME_LEN     = 12,
   parameter int unsigned LOAD_AT       = 10,
   parameter int unsigned SAMPLE_AT     = 11,
   parameter int unsigned CNT_W         = 4,
   parameter bit          SH_TRACK_HIGH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              sh_ctrl_o,
   output logic              restart_o,
   output logic              load_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int unsigned WRAP_AT  = FRAME_LEN;
   localparam int unsigned MIN_W    = cnt_bits(WRAP_AT);
   localparam int unsigned EV_AT [NUM_EVENTS] = '{LOAD_AT, SAMPLE_AT, WRAP_AT};

   generate
      if (CNT_W < MIN_W) begin : g_bad_width
         $error("conv_frame_seq: CNT_W too small for FRAME_LEN");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("conv_frame_seq: CODE_W must be at least 1");
      end
      if (LOAD_AT < 1 || SAMPLE_AT <= LOAD_AT || SAMPLE_AT >= WRAP_AT) begin : g_bad_order
         $error("conv_frame_seq: need 1 <= LOAD_AT < SAMPLE_AT < FRAME_LEN");
      end
   endgenerate

   logic [CNT_W-1:0]      cnt_q;
   logic [NUM_EVENTS-1:0] ev_pulse;
   logic                  sample_pulse;

   frame_counter #(
      .CNT_W (CNT_W),
      .LAST  (WRAP_AT),
      .FIRST (1)
   ) u_cnt (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .cnt_o (cnt_q)
   );

   for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_event
      event_pulse #(
         .CNT_W (CNT_W),
         .AT    (EV_AT[e])
      ) u_ev (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .cnt_i   (cnt_q),
         .pulse_o (ev_pulse[e])
      );
   end

   assign load_o       = ev_pulse[EV_LOAD];
   assign sample_pulse = ev_pulse[EV_SAMPLE];
   assign restart_o    = ev_pulse[EV_WRAP];

   generate
      if (SH_TRACK_HIGH) begin : g_sh_pos
         assign sh_ctrl_o = sample_pulse;
      end else begin : g_sh_neg
         assign sh_ctrl_o = ~sample_pulse;
      end
   endgenerate

   result_hold #(
      .CODE_W (CODE_W)
   ) u_hold (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .take_i (load_o),
      .code_i (code_i),
      .code_o (code_o)
   );
endmodule

// File: rtl/conv_frame_seq_chk.sv
module conv_frame_seq_chk #(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned FRAME_LEN = 12,
   parameter int unsigned LOAD_AT   = 10,
   parameter int unsigned SAMPLE_AT = 11
) (
   input logic              clk,
   input logic              rst,
   input logic [CNT_W-1:0]  cnt,
   input logic              load,
   input logic              sh_pulse,
   input logic              restart,
   input logic [CODE_W-1:0] din,
   input logic [CODE_W-1:0] dout
);
   localparam logic [CNT_W-1:0] LOAD_V   = CNT_W'(LOAD_AT);
   localparam logic [CNT_W-1:0] SAMPLE_V = CNT_W'(SAMPLE_AT);
   localparam logic [CNT_W-1:0] WRAP_V   = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt <= WRAP_V); // R2
   AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (rst)
      cnt == WRAP_V |=> cnt == ONE_V); // R2
   AST_LOAD_AFTER_DECODE: assert property (@(posedge clk) disable iff (rst)
      cnt == LOAD_V |=> load); // R3
   AST_LOAD_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
      load |=> !load); // R3
   AST_SAMPLE_AFTER_DECODE: assert property (@(posedge clk) disable iff (rst)
      cnt == SAMPLE_V |=> sh_pulse); // R4
   AST_RESTART_AT_START: assert property (@(posedge clk) disable iff (rst)
      restart |-> cnt == ONE_V); // R5
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({load, sh_pulse, restart})); // R6
   AST_LOAD_THEN_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      load |=> sh_pulse); // R6
   AST_CAPTURE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |=> dout == $past(din)); // R7
   AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(dout)); // R8
endmodule

bind conv_frame_seq conv_frame_seq_chk #(
   .CODE_W    (CODE_W),
   .CNT_W     (CNT_W),
   .FRAME_LEN (FRAME_LEN),
   .LOAD_AT   (LOAD_AT),
   .SAMPLE_AT (SAMPLE_AT)
) u_chk (
   .clk      (clk_i),
   .rst      (rst_i),
   .cnt      (cnt_q),
   .load     (load_o),
   .sh_pulse (sample_pulse),
   .restart  (restart_o),
   .din      (code_i),
   .dout     (code_o)
);

// File: tb/tb_conv_frame_seq.sv
module tb_conv_frame_seq;
   localparam int CODE_W = 8;
   localparam int FRAME  = 12;
   localparam int LD_AT  = 10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [CODE_W-1:0] code_in = '0;
   logic              sh_ctrl, restart, load;
   logic [CODE_W-1:0] code_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   conv_frame_seq dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .code_i    (code_in),
      .sh_ctrl_o (sh_ctrl),
      .restart_o (restart),
      .load_o    (load),
      .code_o    (code_out)
   );

   function automatic logic [CODE_W-1:0] code_for(input int n, input int salt);
      return CODE_W'(n * 37 + salt * 101 + 11);
   endfunction

   // Strobe expected after rising edge n (n >= 1 counted from reset release):
   // the count during the previous clock is ((n-2) % FRAME) + 1.
   function automatic bit strobe_at(input int n, input int cnt_val);
      if (n < 2) return 1'b0;
      return (((n - 2) % FRAME) + 1) == cnt_val;
   endfunction

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic check_code(input string req, input logic [CODE_W-1:0] act, input logic [CODE_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s code_o actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check_bit(req, "load_o", load, 1'b0);
      check_bit(req, "sh_ctrl_o", sh_ctrl, 1'b0);
      check_bit(req, "restart_o", restart, 1'b0);
      check_code(req, code_out, '0);
   endtask

   // Runs ncyc clocks after reset release, checking every output after every edge.
   task automatic sweep(input int ncyc, input int salt);
      logic [CODE_W-1:0] exp_code = '0;
      bit prev_load = 1'b0;
      int nload = 0;
      for (int n = 1; n <= ncyc; n++) begin
         bit e_ld, e_sh, e_rs;
         code_in = code_for(n, salt);
         @(negedge clk);
         if (prev_load) exp_code = code_for(n, salt); // R7 capture at edge n
         e_ld = strobe_at(n, LD_AT);
         e_sh = strobe_at(n, LD_AT + 1);
         e_rs = strobe_at(n, FRAME);
         if (n == 1) check_idle("R1");
         check_bit("R3", "load_o", load, e_ld);
         check_bit("R4", "sh_ctrl_o", sh_ctrl, e_sh);
         check_bit("R5", "restart_o", restart, e_rs);
         checks++;
         if ((load + sh_ctrl + restart) > 1) begin // R6
            errors++;
            $display("FAIL R6 strobes load=%0b sh=%0b rs=%0b expected at most one", load, sh_ctrl, restart);
         end
         if (prev_load) check_code("R7", code_out, exp_code);
         else           check_code("R8", code_out, exp_code);
         if (load) nload++;
         prev_load = e_ld;
      end
      checks++;
      if (nload != (ncyc - 1) / FRAME) begin // R2 / R6 frame count
         errors++;
         $display("FAIL R2 load pulses actual=%0d expected=%0d", nload, (ncyc - 1) / FRAME);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst = 1'b0;
      sweep(12 * 25 + 1, 0);
      // R9: reset in the middle of a frame
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check_idle("R9");
      rst = 1'b0;
      sweep(12 * 6 + 1, 3);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule